// File: doc/BRIEF.md
# Alternate Mark Inversion Line Encoder

This block is the per-channel transmit front end of a line interface. It turns transmit data into two pulse rails, `line_pos` and `line_neg`, for the line driver. All inputs are sampled on the falling edge of the transmit clock. Both rails are registered on that same edge.

In single-rail operation the block encodes NRZ data with alternate mark inversion:

- A zero becomes a space.
- Each one becomes a pulse of the polarity opposite to the previous pulse.
- For line testing, a rising edge on `viol_req` arms a one-shot bipolar violation. The next one is then sent with the same polarity as the previous pulse.

In dual-rail operation the caller supplies the positive and negative data already split, and the block maps them straight onto the rails.

A channel configured for dual-rail falls back to single-rail by itself once the negative-rail input has been held high long enough. It stays in single-rail until reset. Zero substitution codes and pulse shaping belong elsewhere.

Top module: `ami_tx_encoder`

## Requirements
- R1: While `rst_n` is low at a falling edge, both rails are low after that edge. The first one sent in single-rail after reset is a positive pulse.
- R2: In single-rail, a zero gives a space (both rails low) and leaves the polarity memory unchanged.
- R3: In single-rail, each one gives a pulse opposite in polarity to the previous single-rail pulse: `line_pos`=1 for positive, `line_neg`=1 for negative.
- R4: A low-to-high transition of `viol_req` between two samples arms a violation. The next one sent in single-rail takes the same polarity as the previous pulse, and the violation is then cleared. Holding `viol_req` high arms no further violation.
- R5: An armed violation stays pending across any number of zeros until a one is sent. An edge seen on the same sample as a one applies to that one.
- R6: In dual-rail mode `viol_req` has no effect, and an edge seen there is not remembered once single-rail resumes.
- R7: In dual-rail mode, positive/negative inputs map to the rails as follows: 0/0 gives a space, 1/0 a positive pulse, 0/1 a negative pulse, and 1/1 a space. Dual-rail pulses do not change the single-rail polarity memory.
- R8: With `cfg_dual_rail`=1, sampling `tx_neg` high on HOLD_LIMIT+1 (default 17) consecutive falling edges switches the channel to single-rail from the next sample on. HOLD_LIMIT consecutive highs do not switch it. The switch holds until reset.
- R9: `line_pos` and `line_neg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock; falling edge is the active edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dual_rail | input | 1 | 1 selects dual-rail input, 0 single-rail |
| tx_pos | input | 1 | Single-rail NRZ data, or dual-rail positive data |
| tx_neg | input | 1 | Dual-rail negative data; held high forces single-rail |
| viol_req | input | 1 | Rising edge requests one bipolar violation |
| line_pos | output | 1 | Registered positive pulse rail |
| line_neg | output | 1 | Registered negative pulse rail |

## Verification
The assertions assume that every input is steady around the falling edge of `tx_clk` and that reset is held for at least one falling edge before they apply. The stimulus meets this by changing inputs only on the rising edge of the clock. It keeps reset low for several cycles at start and before re-entering dual-rail. `cfg_dual_rail` changes only between whole samples. The hold-high detector is driven with runs of exactly the limit and one past it, so both sides of the threshold are covered.

// File: rtl/ami_pkg.sv
// Package ami_pkg
// Shared types for the line encoder. Assumes no other package defines them.
package ami_pkg;

    // Pair of pulse rails driven toward the line driver.
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam rail_t RAIL_SPACE = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/ami_rail_detect.sv
// Module ami_rail_detect
// Watches the negative-rail input while dual-rail is configured. Once it is
// seen high on HOLD_LIMIT+1 consecutive falling edges, it raises single_rail,
// which stays set until reset.
// Assumes: inputs steady around the falling edge of clk.
module ami_rail_detect #(
    parameter int HOLD_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_dual,
    input  logic neg_in,
    output logic single_rail
);
    localparam int CW = $clog2(HOLD_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_LIMIT);

    logic [CW-1:0] run_q;
    logic          forced_q;

    // Count consecutive high samples and latch the forced single-rail state.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            forced_q <= 1'b0;
        end else if (cfg_dual && !forced_q) begin
            if (!neg_in) begin
                run_q <= '0;
            end else if (run_q == LIMIT) begin
                forced_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // Effective mode: single-rail when configured so or forced.
    always_comb begin
        single_rail = !cfg_dual || forced_q;
    end

    AST_FORCE_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
        forced_q |=> forced_q); // R8
    AST_RUN_BOUND: assert property (@(negedge clk) disable iff (!rst_n)
        run_q <= LIMIT); // R8
endmodule

// File: rtl/ami_viol_arm.sv
// Module ami_viol_arm
// Detects a rising edge on the violation request and keeps it pending until a
// one is sent in single-rail. Requests are dropped while in dual-rail.
// Assumes: mark_sent is high only when a one leaves in single-rail.
module ami_viol_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic single_rail,
    input  logic req,
    input  logic mark_sent,
    output logic armed
);
    logic req_q;
    logic pend_q;
    logic rise;

    // Edge of the request against its previous sample.
    always_comb begin
        rise  = req && !req_q;
        armed = single_rail && (pend_q || rise);
    end

    // Remember the previous request level and the pending violation.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            req_q  <= req;
            pend_q <= armed && !mark_sent;
        end
    end

    AST_VIOL_ONE_SHOT: assert property (@(negedge clk) disable iff (!rst_n)
        mark_sent |=> !pend_q); // R4
    AST_DUAL_DROPS_VIOL: assert property (@(negedge clk) disable iff (!rst_n)
        !single_rail |=> !pend_q); // R6
endmodule

// File: rtl/ami_line_coder.sv
// Module ami_line_coder
// Registers the two pulse rails. In single-rail it applies alternate mark
// inversion with an optional same-polarity violation. In dual-rail it maps the
// two data inputs directly.
// Assumes: armed is only high in single-rail.
module ami_line_coder
    import ami_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  single_rail,
    input  logic  pos_in,
    input  logic  neg_in,
    input  logic  armed,
    output rail_t line,
    output logic  mark_sent
);
    logic  last_pos_q;
    logic  pol;
    rail_t nxt;

    // Choose the next rail pair from mode, data and violation state.
    always_comb begin
        mark_sent = single_rail && pos_in;
        pol       = armed ? last_pos_q : !last_pos_q;
        nxt       = RAIL_SPACE;
        if (single_rail) begin
            if (pos_in) begin
                nxt.pos = pol;
                nxt.neg = !pol;
            end
        end else begin
            nxt.pos = pos_in && !neg_in;
            nxt.neg = neg_in && !pos_in;
        end
    end

    // Register rails; reset leaves memory "last negative" so a first one is positive.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            line       <= RAIL_SPACE;
            last_pos_q <= 1'b0;
        end else begin
            line <= nxt;
            if (mark_sent) begin
                last_pos_q <= pol;
            end
        end
    end

    AST_NO_DOUBLE_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
        !(line.pos && line.neg)); // R9
    AST_ZERO_IS_SPACE: assert property (@(negedge clk) disable iff (!rst_n)
        (single_rail && !pos_in) |=> (line == RAIL_SPACE)); // R2
    AST_DUAL_POS: assert property (@(negedge clk) disable iff (!rst_n)
        (!single_rail && pos_in && !neg_in) |=> (line.pos && !line.neg)); // R7
    AST_DUAL_NEG: assert property (@(negedge clk) disable iff (!rst_n)
        (!single_rail && !pos_in && neg_in) |=> (line.neg && !line.pos)); // R7
    AST_DUAL_BOTH_SPACE: assert property (@(negedge clk) disable iff (!rst_n)
        (!single_rail && pos_in && neg_in) |=> (line == RAIL_SPACE)); // R7
endmodule

// File: rtl/ami_tx_encoder.sv
// Module ami_tx_encoder
// Top of the per-channel line encoder: mode detection, violation arming and the
// rail coder. All state changes on the falling edge of tx_clk.
// Assumes: inputs steady around the falling edge; reset is synchronous.
module ami_tx_encoder #(
    parameter int HOLD_LIMIT = 16
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic cfg_dual_rail,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic viol_req,
    output logic line_pos,
    output logic line_neg
);
    import ami_pkg::*;

    logic  single_rail;
    logic  armed;
    logic  mark_sent;
    rail_t line;

    ami_rail_detect #(.HOLD_LIMIT(HOLD_LIMIT)) u_detect (
        .clk        (tx_clk),
        .rst_n      (rst_n),
        .cfg_dual   (cfg_dual_rail),
        .neg_in     (tx_neg),
        .single_rail(single_rail)
    );

    ami_viol_arm u_arm (
        .clk        (tx_clk),
        .rst_n      (rst_n),
        .single_rail(single_rail),
        .req        (viol_req),
        .mark_sent  (mark_sent),
        .armed      (armed)
    );

    ami_line_coder u_coder (
        .clk        (tx_clk),
        .rst_n      (rst_n),
        .single_rail(single_rail),
        .pos_in     (tx_pos),
        .neg_in     (tx_neg),
        .armed      (armed),
        .line       (line),
        .mark_sent  (mark_sent)
    );

    // Drive the rail ports from the registered pair.
    always_comb begin
        line_pos = line.pos;
        line_neg = line.neg;
    end

    AST_RESET_SPACE: assert property (@(negedge tx_clk)
        !rst_n |=> (!line_pos && !line_neg)); // R1
endmodule

// File: tb/ami_tx_encoder_tb_top.sv
// Bench for ami_tx_encoder. Scoreboard style: the driver computes the
// expected rails from the requirements and queues them; the monitor compares
// after each falling edge.
module ami_tx_encoder_tb_top;
    localparam int HOLD = 16;

    typedef struct {
        logic  p;
        logic  n;
        string tag;
    } exp_t;

    logic tx_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dual_rail = 1'b0;
    logic tx_pos = 1'b0;
    logic tx_neg = 1'b0;
    logic viol_req = 1'b0;
    logic line_pos;
    logic line_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    // Model state
    logic m_last = 1'b0;
    logic m_pend = 1'b0;
    logic m_vprev = 1'b0;
    logic m_auto = 1'b0;
    int   m_run = 0;

    always #10 tx_clk = ~tx_clk;

    ami_tx_encoder #(.HOLD_LIMIT(HOLD)) dut_i (
        .tx_clk(tx_clk), .rst_n(rst_n), .cfg_dual_rail(cfg_dual_rail),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .viol_req(viol_req),
        .line_pos(line_pos), .line_neg(line_neg)
    );

    // Driver: apply one sample and queue the expected rails for it.
    task automatic step(input logic r, input logic cfg, input logic p,
                        input logic n, input logic v, input string tag);
        exp_t e;
        logic sr, rise, armed, pol;
        @(posedge tx_clk);
        rst_n = r; cfg_dual_rail = cfg; tx_pos = p; tx_neg = n; viol_req = v;
        e.tag = tag;
        if (!r) begin
            e.p = 0; e.n = 0;
            m_last = 0; m_pend = 0; m_vprev = 0; m_auto = 0; m_run = 0;
        end else begin
            sr = !cfg || m_auto;
            rise = v && !m_vprev;
            if (sr) begin
                armed = m_pend || rise;
                if (p) begin
                    pol = armed ? m_last : !m_last;
                    e.p = pol; e.n = !pol;
                    m_last = pol; m_pend = 0;
                end else begin
                    e.p = 0; e.n = 0; m_pend = armed;
                end
            end else begin
                e.p = p && !n; e.n = n && !p; m_pend = 0;
            end
            m_vprev = v;
            if (cfg && !m_auto) begin
                if (!n) m_run = 0;
                else if (m_run == HOLD) m_auto = 1;
                else m_run = m_run + 1;
            end else begin
                m_run = 0;
            end
        end
        q.push_back(e);
    endtask

    // Monitor: compare rails shortly after each falling edge.
    always @(negedge tx_clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (line_pos !== e.p || line_neg !== e.n) begin
                errors++;
                $display("FAIL %s: got pos=%b neg=%b expected pos=%b neg=%b",
                         e.tag, line_pos, line_neg, e.p, e.n);
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R1 reset");
        // R1 first one positive, R2/R3 AMI
        step(1, 0, 1, 0, 0, "R1 first pulse positive");
        step(1, 0, 0, 0, 0, "R2 zero space");
        step(1, 0, 1, 0, 0, "R3 alternate neg");
        step(1, 0, 1, 0, 0, "R3 alternate pos");
        step(1, 0, 0, 0, 0, "R2 zero space");
        step(1, 0, 0, 0, 0, "R2 zero space");
        step(1, 0, 1, 0, 0, "R2 memory kept over zeros");
        step(1, 0, 1, 0, 0, "R3 alternate");
        // R4/R5 violation armed over zeros
        step(1, 0, 0, 0, 1, "R5 arm on zero");
        step(1, 0, 0, 0, 1, "R5 pending zero");
        step(1, 0, 1, 0, 1, "R4 violation same polarity");
        step(1, 0, 1, 0, 1, "R4 held high no repeat");
        step(1, 0, 1, 0, 1, "R4 held high no repeat");
        step(1, 0, 1, 0, 0, "R3 after violation");
        step(1, 0, 1, 0, 1, "R5 edge with one");
        step(1, 0, 1, 0, 0, "R3 after same-cycle violation");
        // R7 dual-rail truth table; R6 violation ignored
        step(1, 1, 0, 0, 0, "R7 dual 00");
        step(1, 1, 1, 0, 0, "R7 dual 10");
        step(1, 1, 0, 1, 1, "R7 dual 01 R6 edge ignored");
        step(1, 1, 1, 1, 1, "R7 dual 11");
        step(1, 1, 1, 0, 1, "R6 dual no violation");
        step(1, 0, 0, 0, 1, "R6 single zero");
        step(1, 0, 1, 0, 1, "R6 edge not remembered R7 memory");
        step(1, 0, 1, 0, 0, "R3 alternate");
        // R8 threshold: HOLD highs do not switch
        for (int i = 0; i < HOLD; i++) step(1, 1, 0, 1, 0, "R8 below limit");
        step(1, 1, 0, 0, 0, "R8 still dual");
        step(1, 1, 1, 0, 0, "R8 still dual pos");
        // HOLD+1 highs switch
        for (int i = 0; i <= HOLD; i++) step(1, 1, 0, 1, 0, "R8 run to limit");
        step(1, 1, 1, 1, 0, "R8 now single-rail");
        step(1, 1, 1, 0, 0, "R8 sticky single");
        step(1, 1, 0, 1, 0, "R8 sticky zero space");
        step(1, 1, 1, 1, 1, "R8 R4 violation after switch");
        // reset restores dual-rail
        step(0, 1, 0, 0, 0, "R1 reset again");
        step(1, 1, 1, 1, 0, "R8 reset clears force");
        step(1, 1, 0, 1, 0, "R7 dual neg");
        step(1, 0, 1, 0, 0, "R1 first after reset");
        step(1, 0, 0, 0, 0, "R2 drain");
        @(negedge tx_clk); #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule